// File: doc/BRIEF.md
# PWM Tone and Volume Generator

This block makes an audio tone and a volume-shaped pulse train from one fast system clock, nominally 16 MHz. A 9-bit compare counter divides the clock into a PWM carrier frame, set up for 32 kHz to 64 kHz. A 6-bit compare counter counts those frames, and a toggle stage after it gives a square-wave tone with exactly 50% duty, set up for roughly 245 Hz to 6 kHz. An RS-style latch sets the PWM duty within each carrier frame from a volume value. The duty runs from fully off to fully on.

Software writes four things: a carrier period value, a tone divider value, a volume value, and a control word with a run bit and an output-mode bit. Each of the three numeric values goes first into a holding register. It moves into the working compare buffer only when the counter that uses it wraps, so a write never cuts a period short. In split mode the tone pin carries the plain tone and the amplitude pin carries the PWM. In combined mode the tone pin carries tone AND PWM, which can drive a speaker stage directly. The amplitude pin keeps the PWM in both modes.

Top module: `sg_tone_volume`

## Requirements
- R1: After reset the run bit is clear, and both `tone_pin` and `amp_pin` are low.
- R2: While the run bit is 0, both outputs are low and the counters, toggle stage and PWM latch are held at zero. The run bit is written through `ctl_we`. Clearing it forces both outputs low from the next cycle on.
- R3: With carrier buffer value N, one PWM frame lasts N+1 clock cycles. Consecutive rising edges of `amp_pin` are N+1 cycles apart whenever 0 < V < N+1.
- R4: With tone buffer value T, the tone toggles once every (T+1) frames. Each high phase and each low phase therefore lasts (N+1)(T+1) cycles.
- R5: With volume buffer value V, `amp_pin` is high for min(V, N+1) cycles of every frame. V = 0 keeps it low for the whole frame.
- R6: When V >= N+1, `amp_pin` stays high continuously.
- R7: A new carrier, tone or volume value takes effect only at the end of the frame (or tone half-period) in progress. A carrier value written mid-frame leaves that frame at its old length.
- R8: With the mode bit 0, `tone_pin` carries the 50% tone and `amp_pin` carries the PWM.
- R9: With the mode bit 1, `tone_pin` carries the AND of tone and PWM. Over one full tone period it is high for (T+1)*min(V, N+1) cycles. `amp_pin` still carries the PWM.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| freq_lo_we | input | 1 | Write strobe for the carrier period holding register |
| freq_lo_d | input | 9 | Carrier period value N (frame = N+1 cycles) |
| freq_hi_we | input | 1 | Write strobe for the tone divider holding register |
| freq_hi_d | input | 6 | Tone divider value T (half-period = T+1 frames) |
| vol_we | input | 1 | Write strobe for the volume holding register |
| vol_d | input | 9 | Volume value V (high cycles per frame) |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_pwr | input | 1 | Run bit: 1 runs the generator, 0 holds it in reset |
| ctl_sel | input | 1 | Output mode: 0 split, 1 combined on the tone pin |
| tone_pin | output | 1 | Tone, or tone AND PWM in combined mode |
| amp_pin | output | 1 | PWM volume signal |

## Verification
A register write is captured at the next clock edge. A run-bit change shows at the outputs right after that edge, because the pins are gated by the captured run bit. Timing results are therefore only due a whole frame or tone half-period after a write. The bench first waits several full tone periods, then counts high cycles over windows that are exact multiples of the frame or tone period. Those counts do not depend on where the window starts. Edge-to-edge measurements sample on the falling clock edge and synchronise to an observed rising edge of the pin first. The mid-frame update check counts cycles from a seen frame start, so the old and new frame lengths land on exact cycle numbers.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam int SG_FREQ_W = 9;
  localparam int SG_TONE_W = 6;

  typedef struct packed {
    logic run;
    logic mix;
  } sg_ctl_t;
endpackage

// File: rtl/sg_rst_sync.sv
module sg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/sg_cmp_counter.sv
// Up-counter with a compare buffer reloaded from a holding value at wrap.
module sg_cmp_counter #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         adv,
  input  logic [W-1:0] hold_val,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cmp_buf,
  output logic         wrap
);
  logic [W-1:0] cnt_d, buf_d;

  assign wrap = run & adv & (cnt == cmp_buf);

  always_comb begin
    cnt_d = cnt;
    buf_d = cmp_buf;
    if (!run) begin
      cnt_d = '0;
      buf_d = hold_val;
    end else if (wrap) begin
      cnt_d = '0;
      buf_d = hold_val;
    end else if (adv) begin
      cnt_d = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      cmp_buf <= '0;
    end else begin
      cnt     <= cnt_d;
      cmp_buf <= buf_d;
    end
  end
endmodule

// File: rtl/sg_pwm_latch.sv
// Set at frame start (unless the next volume is zero), cleared when the
// frame count reaches the volume, so V cycles of each frame are high.
module sg_pwm_latch #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         frame_end,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] hold_val,
  output logic [W-1:0] vol_buf,
  output logic         pwm
);
  localparam int CW = W + 1;

  logic [W-1:0] vol_d;
  logic         pwm_d;
  logic         set_ok;
  logic         clr_hit;

  assign set_ok  = (hold_val != '0);
  assign clr_hit = ({1'b0, cnt} + CW'(1)) == {1'b0, vol_buf};

  always_comb begin
    vol_d = vol_buf;
    pwm_d = pwm;
    if (!run) begin
      vol_d = hold_val;
      pwm_d = 1'b0;
    end else if (frame_end) begin
      vol_d = hold_val;
      pwm_d = set_ok;
    end else if (clr_hit) begin
      pwm_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vol_buf <= '0;
      pwm     <= 1'b0;
    end else begin
      vol_buf <= vol_d;
      pwm     <= pwm_d;
    end
  end
endmodule

// File: rtl/sg_tone_volume.sv
module sg_tone_volume #(
  parameter int FW = sg_pkg::SG_FREQ_W,
  parameter int TW = sg_pkg::SG_TONE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          freq_lo_we,
  input  logic [FW-1:0] freq_lo_d,
  input  logic          freq_hi_we,
  input  logic [TW-1:0] freq_hi_d,
  input  logic          vol_we,
  input  logic [FW-1:0] vol_d,
  input  logic          ctl_we,
  input  logic          ctl_pwr,
  input  logic          ctl_sel,
  output logic          tone_pin,
  output logic          amp_pin
);
  import sg_pkg::*;

  logic          rst_n_sync;
  logic [FW-1:0] flo_q, flo_d;
  logic [TW-1:0] fhi_q, fhi_d;
  logic [FW-1:0] vol_q, vol_nx;
  sg_ctl_t       ctl_q, ctl_d;
  logic          run, mix;

  logic [FW-1:0] cnt_f, buf_f;
  logic [TW-1:0] cnt_t, buf_t;
  logic [FW-1:0] buf_v;
  logic          f_wrap, t_wrap;
  logic          pwm;
  logic          div_q, div_d;

  sg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_out(rst_n_sync)
  );

  // Holding registers: next state
  always_comb begin
    flo_d  = freq_lo_we ? freq_lo_d : flo_q;
    fhi_d  = freq_hi_we ? freq_hi_d : fhi_q;
    vol_nx = vol_we     ? vol_d     : vol_q;
    ctl_d  = ctl_q;
    if (ctl_we) begin
      ctl_d.run = ctl_pwr;
      ctl_d.mix = ctl_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      flo_q <= '0;
      fhi_q <= '0;
      vol_q <= '0;
      ctl_q <= '0;
    end else begin
      flo_q <= flo_d;
      fhi_q <= fhi_d;
      vol_q <= vol_nx;
      ctl_q <= ctl_d;
    end
  end

  assign run = ctl_q.run;
  assign mix = ctl_q.mix;

  sg_cmp_counter #(.W(FW)) u_frame (
    .clk(clk), .rst_n(rst_n_sync), .run(run), .adv(1'b1),
    .hold_val(flo_q), .cnt(cnt_f), .cmp_buf(buf_f), .wrap(f_wrap)
  );

  sg_cmp_counter #(.W(TW)) u_tone (
    .clk(clk), .rst_n(rst_n_sync), .run(run), .adv(f_wrap),
    .hold_val(fhi_q), .cnt(cnt_t), .cmp_buf(buf_t), .wrap(t_wrap)
  );

  sg_pwm_latch #(.W(FW)) u_pwm (
    .clk(clk), .rst_n(rst_n_sync), .run(run), .frame_end(f_wrap),
    .cnt(cnt_f), .hold_val(vol_q), .vol_buf(buf_v), .pwm(pwm)
  );

  // Divide-by-two tone stage
  always_comb begin
    div_d = div_q;
    if (!run)        div_d = 1'b0;
    else if (t_wrap) div_d = ~div_q;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) div_q <= 1'b0;
    else             div_q <= div_d;
  end

  assign tone_pin = run & (mix ? (div_q & pwm) : div_q);
  assign amp_pin  = run & pwm;
endmodule

// File: rtl/sg_tone_volume_chk.sv
module sg_tone_volume_chk #(
  parameter int FW = 9,
  parameter int TW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          mix,
  input logic          f_wrap,
  input logic          t_wrap,
  input logic [FW-1:0] cnt_f,
  input logic [FW-1:0] buf_f,
  input logic [TW-1:0] buf_t,
  input logic          div_q,
  input logic          pwm,
  input logic          tone_pin,
  input logic          amp_pin
);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!tone_pin && !amp_pin));

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_f <= buf_f);

  a_r4_toggle_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(div_q) && $past(run)) |-> $past(t_wrap));

  a_r5_rise_at_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm) |-> (cnt_f == '0));

  a_r7_carrier_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !f_wrap) |=> $stable(buf_f));

  a_r7_tone_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !t_wrap) |=> $stable(buf_t));

  a_r9_mix_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (mix && tone_pin) |-> amp_pin);
endmodule

bind sg_tone_volume sg_tone_volume_chk #(.FW(FW), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n_sync), .run(run), .mix(mix),
  .f_wrap(f_wrap), .t_wrap(t_wrap), .cnt_f(cnt_f), .buf_f(buf_f),
  .buf_t(buf_t), .div_q(div_q), .pwm(pwm),
  .tone_pin(tone_pin), .amp_pin(amp_pin)
);

// File: tb/sg_tone_volume_test.sv
module sg_tone_volume_test;
  localparam int FW = 9;
  localparam int TW = 6;

  // {mix, N[8:0], T[5:0], V[8:0]}
  localparam int NV = 6;
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 9'd7, 6'd1, 9'd3},
    {1'b0, 9'd4, 6'd2, 9'd5},
    {1'b0, 9'd9, 6'd0, 9'd0},
    {1'b1, 9'd5, 6'd3, 9'd2},
    {1'b1, 9'd3, 6'd1, 9'd4},
    {1'b0, 9'd8, 6'd2, 9'd200}
  };

  logic clk = 0;
  logic rst_n;
  logic freq_lo_we, freq_hi_we, vol_we, ctl_we, ctl_pwr, ctl_sel;
  logic [FW-1:0] freq_lo_d, vol_d;
  logic [TW-1:0] freq_hi_d;
  logic tone_pin, amp_pin;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sg_tone_volume #(.FW(FW), .TW(TW)) uut (
    .clk(clk), .rst_n(rst_n),
    .freq_lo_we(freq_lo_we), .freq_lo_d(freq_lo_d),
    .freq_hi_we(freq_hi_we), .freq_hi_d(freq_hi_d),
    .vol_we(vol_we), .vol_d(vol_d),
    .ctl_we(ctl_we), .ctl_pwr(ctl_pwr), .ctl_sel(ctl_sel),
    .tone_pin(tone_pin), .amp_pin(amp_pin)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int min2(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic write_ctl(input logic pwr, input logic sel);
    @(negedge clk);
    ctl_we = 1; ctl_pwr = pwr; ctl_sel = sel;
    @(negedge clk);
    ctl_we = 0;
  endtask

  task automatic write_vals(input int n, input int t, input int v);
    @(negedge clk);
    freq_lo_we = 1; freq_lo_d = FW'(n);
    freq_hi_we = 1; freq_hi_d = TW'(t);
    vol_we = 1; vol_d = FW'(v);
    @(negedge clk);
    freq_lo_we = 0; freq_hi_we = 0; vol_we = 0;
  endtask

  task automatic count_high(input int win, output int hi_amp, output int hi_tone);
    hi_amp = 0; hi_tone = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (amp_pin) hi_amp++;
      if (tone_pin) hi_tone++;
    end
  endtask

  task automatic wait_amp_rise(input int lim);
    logic prev;
    prev = amp_pin;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (amp_pin && !prev) break;
      prev = amp_pin;
    end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n, t, v, p, ha, ht, cyc, run_len;
    logic mix, prev;
    freq_lo_we = 0; freq_hi_we = 0; vol_we = 0; ctl_we = 0;
    ctl_pwr = 0; ctl_sel = 0; freq_lo_d = '0; freq_hi_d = '0; vol_d = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 tone after reset", int'(tone_pin), 0);
    check("R1 amp after reset", int'(amp_pin), 0);

    // R2: values written while stopped produce nothing
    write_vals(3, 0, 4);
    count_high(20, ha, ht);
    check("R2 amp while stopped", ha, 0);
    check("R2 tone while stopped", ht, 0);

    // Vector table
    for (int k = 0; k < NV; k++) begin
      mix = VEC[k][24];
      n = int'(VEC[k][23:15]);
      t = int'(VEC[k][14:9]);
      v = int'(VEC[k][8:0]);
      p = (n + 1) * (t + 1);
      write_ctl(0, 0);
      write_vals(n, t, v);
      write_ctl(1, mix);
      repeat (4 * p + 10) @(negedge clk);
      count_high(4 * (n + 1), ha, ht);
      if (v >= n + 1)
        check("R6 amp always high", ha, 4 * (n + 1));
      else
        check("R5 amp high per 4 frames", ha, 4 * min2(v, n + 1));
      count_high(2 * p, ha, ht);
      if (mix)
        check("R9 combined tone high per period", ht, (t + 1) * min2(v, n + 1));
      else
        check("R8 split tone high per period", ht, p);
      if (!mix) begin
        // R4: high phase length from a rising edge
        prev = tone_pin;
        for (int i = 0; i < 2 * p + 2; i++) begin
          @(negedge clk);
          if (tone_pin && !prev) break;
          prev = tone_pin;
        end
        run_len = 0;
        while (tone_pin && run_len < 2 * p + 2) begin
          run_len++;
          @(negedge clk);
        end
        check("R4 tone high phase", run_len, p);
      end
      if (v > 0 && v < n + 1) begin
        // R3: frame length between PWM rises
        wait_amp_rise(2 * (n + 1));
        cyc = 0; prev = amp_pin;
        for (int i = 0; i < 2 * (n + 1); i++) begin
          @(negedge clk);
          cyc++;
          if (amp_pin && !prev) break;
          prev = amp_pin;
        end
        check("R3 frame length", cyc, n + 1);
      end
    end

    // R7: carrier value written mid-frame applies from the next frame
    write_ctl(0, 0);
    write_vals(9, 1, 2);
    write_ctl(1, 0);
    repeat (60) @(negedge clk);
    wait_amp_rise(40);
    cyc = 0; prev = amp_pin;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      cyc++;
      if (cyc == 2) begin freq_lo_we = 1; freq_lo_d = 9'd4; end
      if (cyc == 3) freq_lo_we = 0;
      if (amp_pin && !prev) break;
      prev = amp_pin;
    end
    check("R7 old frame completes", cyc, 10);
    cyc = 0; prev = amp_pin;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      cyc++;
      if (amp_pin && !prev) break;
      prev = amp_pin;
    end
    check("R7 new frame length", cyc, 5);

    // R2: stopping mid-run silences both pins at once
    write_ctl(1, 0);
    write_vals(4, 0, 5);
    repeat (30) @(negedge clk);
    write_ctl(0, 0);
    count_high(30, ha, ht);
    check("R2 amp after stop", ha, 0);
    check("R2 tone after stop", ht, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule